// File: doc/BRIEF.md
# Bitmask Dictionary Codeword Decoder

This block turns a stream of already-aligned variable-length codewords back into 8-bit configuration words. Each codeword arrives whole, left-aligned in a 9-bit field, together with its length in bits. The block recognises four kinds of code:

- a raw literal;
- an exact hit on one of two dictionary entries;
- a dictionary hit corrected by a 2-bit XOR patch;
- a run code that replays the most recently produced word a given number of times.

Decoded words leave through a valid/ready output. A small write port fills the dictionary before decoding begins.

Codewords are taken one per cycle whenever the output register is free. A run code stalls the codeword input while its copies drain, one copy per cycle that the output accepts. A run code that arrives before any word exists produces nothing and raises a sticky error flag.

Top module: `bitmask_dict_decoder`

## Requirements
- R1: After reset, `out_valid` and `err_run_empty` are low, `cw_ready` is high, and every dictionary entry is zero.
- R2: A cycle with `dict_we` high stores `dict_data` into the entry selected by `dict_addr`, and that value is used by later codes naming that entry.
- R3: A code whose bit 8 (the first bit) is 1 is a raw code of length 9, and bits 7..0 are emitted unchanged as the output word.
- R4: A code starting with the bits 0,1 is an exact code of length 3; its third bit (bit 6) selects the dictionary entry that is emitted.
- R5: A code starting with 0,0 and a non-zero pattern is a patch code of length 7. Bits 6..5 are the position p, bits 4..3 the pattern, and bit 2 the entry index. The output is entry XOR (pattern shifted left by 6-2*p), so p=3 patches bits 1..0 and p=0 patches bits 7..6.
- R6: A code starting with 0,0 with pattern 00 is a run code. The 3-bit count {bit 6, bit 5, bit 2} gives how many extra copies of the last emitted word follow, in order. A count of zero emits nothing, and a run after a run repeats the same word.
- R7: While copies of a run remain to be emitted, `cw_ready` is low. It returns high in the cycle after the last copy is handed over.
- R8: A run code accepted before any word has been emitted since reset produces no output and sets `err_run_empty`. The flag stays high until reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` holds its value and no new codeword is accepted. No word is lost or duplicated under any pattern of `out_ready`.
- R10: A decoded word is presented on `out_word` with `out_valid` high in the cycle after its code is accepted, and one codeword per cycle is accepted while the output is taken every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dict_we | input | 1 | Dictionary write strobe |
| dict_addr | input | 1 | Dictionary entry to write |
| dict_data | input | 8 | Value written into the entry |
| cw_valid | input | 1 | Codeword present |
| cw_ready | output | 1 | Codeword taken when high together with `cw_valid` |
| cw_data | input | 9 | Codeword, first bit at bit 8, left-aligned |
| cw_len | input | 4 | Codeword length in bits |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 8 | Decoded configuration word |
| err_run_empty | output | 1 | Sticky flag: run code seen with no previous word |

## Verification
A corrupted remembered word or run counter does not show up until the next run code, and then it surfaces as the wrong value or the wrong number of copies. The bench therefore follows every run with a normal code and compares the complete output sequence, not only single words.

A wrong dictionary entry or patch position shows on the very next output word, one cycle after acceptance. A stuck run counter shows as `cw_ready` staying low beyond the number of cycles given by the count. A lost or duplicated word under backpressure shows as a shifted sequence, which the bench exposes by comparing the whole stream with a randomly stalled `out_ready`.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
   typedef enum logic [1:0] {
      KIND_RAW   = 2'd0,
      KIND_EXACT = 2'd1,
      KIND_PATCH = 2'd2,
      KIND_RUN   = 2'd3
   } code_kind_e;
endpackage

// File: rtl/bmd_dict.sv
module bmd_dict #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] entry_q [DEPTH];

   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("bmd_dict: DEPTH must be a power of two, at least 2");
      end
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               entry_q[e] <= '0;
            end else if (we && waddr == IDX_W'(e)) begin
               entry_q[e] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = entry_q[raddr];

   // R2: a write lands in the addressed entry
   p_dict_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(we) |-> entry_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/bmd_field_decode.sv
module bmd_field_decode
   import bmd_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int MASK_W     = 2,
   parameter int DICT_DEPTH = 2,
   localparam int IDX_W     = $clog2(DICT_DEPTH),
   localparam int NPOS      = WORD_W / MASK_W,
   localparam int POS_W     = $clog2(NPOS),
   localparam int RAW_LEN   = 1 + WORD_W,
   localparam int PATCH_LEN = 2 + POS_W + MASK_W + IDX_W,
   localparam int CW_W      = (RAW_LEN > PATCH_LEN) ? RAW_LEN : PATCH_LEN,
   localparam int CNT_W     = POS_W + IDX_W
) (
   input  logic [CW_W-1:0]   cw_data,
   output logic [IDX_W-1:0]  dict_idx,
   input  logic [WORD_W-1:0] dict_word,
   output code_kind_e        kind,
   output logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  run_cnt
);
   localparam int TOP = CW_W - 1;

   logic [WORD_W-1:0] raw_word;
   logic [IDX_W-1:0]  exact_idx;
   logic [IDX_W-1:0]  patch_idx;
   logic [POS_W-1:0]  pos;
   logic [MASK_W-1:0] pat;
   logic [WORD_W-1:0] placed [NPOS];

   generate
      if (WORD_W % MASK_W != 0 || (1 << POS_W) != NPOS) begin : g_bad_geom
         $error("bmd_field_decode: WORD_W/MASK_W must be a power of two");
      end
      // one candidate per position, position 0 at the most significant end
      for (genvar p = 0; p < NPOS; p++) begin : g_place
         assign placed[p] = WORD_W'(pat) << ((NPOS - 1 - p) * MASK_W);
      end
   endgenerate

   assign raw_word  = cw_data[TOP-1 -: WORD_W];
   assign exact_idx = cw_data[TOP-2 -: IDX_W];
   assign pos       = cw_data[TOP-2 -: POS_W];
   assign pat       = cw_data[TOP-2-POS_W -: MASK_W];
   assign patch_idx = cw_data[TOP-2-POS_W-MASK_W -: IDX_W];
   assign run_cnt   = {pos, patch_idx};
   assign dict_idx  = cw_data[TOP-1] ? exact_idx : patch_idx;

   always_comb begin
      if (cw_data[TOP]) begin
         kind = KIND_RAW;
         word = raw_word;
      end else if (cw_data[TOP-1]) begin
         kind = KIND_EXACT;
         word = dict_word;
      end else if (pat == '0) begin
         kind = KIND_RUN;
         word = dict_word;
      end else begin
         kind = KIND_PATCH;
         word = dict_word ^ placed[pos];
      end
   end
endmodule

// File: rtl/bmd_out_stage.sv
module bmd_out_stage
   import bmd_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  code_kind_e        kind,
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  run_cnt,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              run_busy,
   output logic              err_run_empty
);
   logic [WORD_W-1:0] last_q;
   logic              have_last_q;
   logic [CNT_W-1:0]  left_q;
   logic              slot_free;

   assign slot_free = !out_valid || out_ready;
   assign run_busy  = (left_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_word      <= '0;
         last_q        <= '0;
         have_last_q   <= 1'b0;
         left_q        <= '0;
         err_run_empty <= 1'b0;
      end else begin
         if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
         if (run_busy) begin
            if (slot_free) begin
               out_valid <= 1'b1;
               out_word  <= last_q;
               left_q    <= left_q - 1'b1;
            end
         end else if (accept) begin
            if (kind == KIND_RUN) begin
               if (!have_last_q) begin
                  err_run_empty <= 1'b1;
               end else begin
                  left_q <= run_cnt;
               end
            end else begin
               out_valid   <= 1'b1;
               out_word    <= word;
               last_q      <= word;
               have_last_q <= 1'b1;
            end
         end
      end
   end

   // R9: a stalled word stays put
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   // R8: error flag is sticky
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_run_empty |=> err_run_empty);

   // R8: an orphan run emits nothing
   p_orphan_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && kind == KIND_RUN && !have_last_q |=> !out_valid);

   // R6: during a run the presented word never changes
   p_run_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_busy && out_valid |=> out_valid && $stable(out_word));
endmodule

// File: rtl/bitmask_dict_decoder.sv
module bitmask_dict_decoder
   import bmd_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int MASK_W     = 2,
   parameter int DICT_DEPTH = 2,
   localparam int IDX_W     = $clog2(DICT_DEPTH),
   localparam int NPOS      = WORD_W / MASK_W,
   localparam int POS_W     = $clog2(NPOS),
   localparam int RAW_LEN   = 1 + WORD_W,
   localparam int EXACT_LEN = 2 + IDX_W,
   localparam int PATCH_LEN = 2 + POS_W + MASK_W + IDX_W,
   localparam int CW_W      = (RAW_LEN > PATCH_LEN) ? RAW_LEN : PATCH_LEN,
   localparam int LEN_W     = $clog2(CW_W + 1),
   localparam int CNT_W     = POS_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dict_we,
   input  logic [IDX_W-1:0]  dict_addr,
   input  logic [WORD_W-1:0] dict_data,
   input  logic              cw_valid,
   output logic              cw_ready,
   input  logic [CW_W-1:0]   cw_data,
   input  logic [LEN_W-1:0]  cw_len,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              err_run_empty
);
   logic [IDX_W-1:0]  rd_idx;
   logic [WORD_W-1:0] rd_word;
   code_kind_e        kind;
   logic [WORD_W-1:0] dec_word;
   logic [CNT_W-1:0]  run_cnt;
   logic              run_busy;
   logic              accept;

   generate
      if (MASK_W < 1 || WORD_W < 2 * MASK_W) begin : g_bad_mask
         $error("bitmask_dict_decoder: mask must fit at least twice in a word");
      end
   endgenerate

   assign cw_ready = !run_busy && (!out_valid || out_ready);
   assign accept   = cw_valid && cw_ready;

   bmd_dict #(.WORD_W(WORD_W), .DEPTH(DICT_DEPTH)) dict_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dict_we),
      .waddr (dict_addr),
      .wdata (dict_data),
      .raddr (rd_idx),
      .rdata (rd_word)
   );

   bmd_field_decode #(.WORD_W(WORD_W), .MASK_W(MASK_W), .DICT_DEPTH(DICT_DEPTH)) dec_i (
      .cw_data   (cw_data),
      .dict_idx  (rd_idx),
      .dict_word (rd_word),
      .kind      (kind),
      .word      (dec_word),
      .run_cnt   (run_cnt)
   );

   bmd_out_stage #(.WORD_W(WORD_W), .CNT_W(CNT_W)) out_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (accept),
      .kind          (kind),
      .word          (dec_word),
      .run_cnt       (run_cnt),
      .out_ready     (out_ready),
      .out_valid     (out_valid),
      .out_word      (out_word),
      .run_busy      (run_busy),
      .err_run_empty (err_run_empty)
   );

   // R3: raw codes carry the full literal length
   p_raw_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && kind == KIND_RAW |-> cw_len == LEN_W'(RAW_LEN));

   // R4: exact codes are short
   p_exact_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && kind == KIND_EXACT |-> cw_len == LEN_W'(EXACT_LEN));

   // R5: patch and run codes share one length
   p_patch_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (kind == KIND_PATCH || kind == KIND_RUN) |-> cw_len == LEN_W'(PATCH_LEN));

   // R10: an accepted literal shows up on the next cycle
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept && kind != KIND_RUN |=> out_valid && out_word == $past(dec_word));
endmodule

// File: tb/bitmask_dict_decoder_tb_top.sv
module bitmask_dict_decoder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dict_we = 1'b0;
   logic [0:0] dict_addr = '0;
   logic [7:0] dict_data = '0;
   logic       cw_valid = 1'b0;
   logic       cw_ready;
   logic [8:0] cw_data = '0;
   logic [3:0] cw_len = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_word;
   logic       err_run_empty;

   int n_checks = 0;
   int n_fail = 0;

   logic [7:0] got [256];
   logic [7:0] exp_q [256];
   int n_got = 0;
   int n_exp = 0;

   bit         stall_mode = 1'b0;
   logic [7:0] lfsr = 8'h5D;
   bit         prev_stall = 1'b0;
   logic [7:0] prev_word = '0;

   localparam logic [7:0] D0 = 8'hA5;
   localparam logic [7:0] D1 = 8'h3C;

   always #2.5 clk = ~clk;

   bitmask_dict_decoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .dict_we(dict_we), .dict_addr(dict_addr), .dict_data(dict_data),
      .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data), .cw_len(cw_len),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .err_run_empty(err_run_empty)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   // consumer pattern, changed only at falling edges
   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
   end

   // monitor: records handshakes, checks hold under stall (R9)
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (prev_stall) begin
            check(out_valid && out_word == prev_word, "R9", "held word",
                  int'(out_word), int'(prev_word));
         end
         if (out_valid && out_ready) begin
            got[n_got[7:0]] = out_word;
            n_got++;
         end
         prev_stall = out_valid && !out_ready;
         prev_word  = out_word;
      end else begin
         prev_stall = 1'b0;
      end
   end

   function automatic logic [7:0] patch(input logic [7:0] d, input int pos, input logic [1:0] pat);
      return d ^ (8'(pat) << (6 - 2 * pos));
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cw_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n_got = 0;
      n_exp = 0;
   endtask

   task automatic send(input logic [8:0] code, input logic [3:0] len);
      @(negedge clk);
      cw_valid = 1'b1;
      cw_data  = code;
      cw_len   = len;
      forever begin
         #1;
         if (cw_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      cw_valid = 1'b0;
   endtask

   task automatic send_raw(input logic [7:0] v);
      send({1'b1, v}, 4'd9);
   endtask
   task automatic send_exact(input logic idx);
      send({2'b01, idx, 6'b0}, 4'd3);
   endtask
   task automatic send_patch(input logic [1:0] pos, input logic [1:0] pat, input logic idx);
      send({2'b00, pos, pat, idx, 2'b0}, 4'd7);
   endtask
   task automatic send_run(input logic [2:0] cnt);
      send({2'b00, cnt[2:1], 2'b00, cnt[0], 2'b0}, 4'd7);
   endtask

   task automatic expect_word(input logic [7:0] v);
      exp_q[n_exp[7:0]] = v;
      n_exp++;
   endtask

   task automatic drain_and_compare(input string req);
      for (int i = 0; i < 300 && n_got < n_exp; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      check(n_got == n_exp, req, "word count", n_got, n_exp);
      for (int i = 0; i < n_exp && i < n_got; i++) begin
         check(got[i] == exp_q[i], req, $sformatf("word %0d", i), int'(got[i]), int'(exp_q[i]));
      end
      n_got = 0;
      n_exp = 0;
   endtask

   task automatic load_dict();
      @(negedge clk);
      dict_we = 1'b1; dict_addr = 1'b0; dict_data = D0;
      @(negedge clk);
      dict_addr = 1'b1; dict_data = D1;
      @(negedge clk);
      dict_we = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      check(cw_ready == 1'b1, "R1", "cw_ready", int'(cw_ready), 1);
      check(err_run_empty == 1'b0, "R1", "err flag", int'(err_run_empty), 0);
      // entries start at zero before any write
      send_exact(1'b1);
      expect_word(8'h00);
      drain_and_compare("R1");
   endtask

   task automatic t_raw();
      logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
      foreach (vals[i]) begin
         send_raw(vals[i]);
         expect_word(vals[i]);
      end
      drain_and_compare("R3");
   endtask

   task automatic t_exact();
      load_dict();
      send_exact(1'b0); expect_word(D0);
      send_exact(1'b1); expect_word(D1);
      send_exact(1'b0); expect_word(D0);
      drain_and_compare("R4");
      // rewrite an entry and see the new value used (R2)
      @(negedge clk);
      dict_we = 1'b1; dict_addr = 1'b1; dict_data = 8'hE7;
      @(negedge clk);
      dict_we = 1'b0;
      send_exact(1'b1); expect_word(8'hE7);
      drain_and_compare("R2");
      load_dict();
   endtask

   task automatic t_patch();
      for (int p = 0; p < 4; p++) begin
         send_patch(2'(p), 2'b01, 1'b0); expect_word(patch(D0, p, 2'b01));
         send_patch(2'(p), 2'b11, 1'b1); expect_word(patch(D1, p, 2'b11));
         send_patch(2'(p), 2'b10, 1'b0); expect_word(patch(D0, p, 2'b10));
      end
      drain_and_compare("R5");
   endtask

   task automatic t_run();
      send_raw(8'h42); expect_word(8'h42);
      send_run(3'd4);
      for (int k = 0; k < 4; k++) expect_word(8'h42);
      // send returns at the falling edge after the run code is taken
      for (int k = 0; k < 4; k++) begin
         if (k > 0) @(negedge clk);
         #1;
         check(cw_ready == 1'b0, "R7", $sformatf("ready during copy %0d", k), int'(cw_ready), 0);
      end
      @(negedge clk);
      #1;
      check(cw_ready == 1'b1, "R7", "ready after last copy", int'(cw_ready), 1);
      drain_and_compare("R6");
      // zero count, run after run, run after patched word
      send_raw(8'h11); expect_word(8'h11);
      send_run(3'd0);
      send_raw(8'h22); expect_word(8'h22);
      send_exact(1'b1); expect_word(D1);
      send_run(3'd2); expect_word(D1); expect_word(D1);
      send_run(3'd3); expect_word(D1); expect_word(D1); expect_word(D1);
      send_patch(2'd2, 2'b11, 1'b0); expect_word(patch(D0, 2, 2'b11));
      send_run(3'd7);
      for (int k = 0; k < 7; k++) expect_word(patch(D0, 2, 2'b11));
      drain_and_compare("R6");
   endtask

   task automatic t_backpressure();
      stall_mode = 1'b1;
      send_raw(8'hC3); expect_word(8'hC3);
      send_run(3'd5);
      for (int k = 0; k < 5; k++) expect_word(8'hC3);
      send_patch(2'd3, 2'b01, 1'b1); expect_word(patch(D1, 3, 2'b01));
      send_exact(1'b0); expect_word(D0);
      send_run(3'd1); expect_word(D0);
      send_raw(8'h0F); expect_word(8'h0F);
      drain_and_compare("R9");
      stall_mode = 1'b0;
   endtask

   task automatic t_throughput();
      // back-to-back accepts: one word per cycle (R10)
      int start_cnt;
      @(negedge clk);
      cw_valid = 1'b1; cw_data = {1'b1, 8'h31}; cw_len = 4'd9;
      #1;
      check(cw_ready == 1'b1, "R10", "ready cycle 0", int'(cw_ready), 1);
      @(negedge clk);
      cw_data = {1'b1, 8'h32};
      #1;
      check(out_valid && out_word == 8'h31, "R10", "first word next cycle", int'(out_word), 8'h31);
      check(cw_ready == 1'b1, "R10", "ready cycle 1", int'(cw_ready), 1);
      @(negedge clk);
      cw_valid = 1'b0;
      #1;
      check(out_valid && out_word == 8'h32, "R10", "second word next cycle", int'(out_word), 8'h32);
      start_cnt = 0;
      repeat (4) @(negedge clk);
      n_got = 0; n_exp = 0;
   endtask

   task automatic t_orphan_run();
      do_reset();
      load_dict();
      send_run(3'd3);
      repeat (10) @(negedge clk);
      #1;
      check(n_got == 0, "R8", "words after orphan run", n_got, 0);
      check(err_run_empty == 1'b1, "R8", "err flag set", int'(err_run_empty), 1);
      send_raw(8'h99); expect_word(8'h99);
      drain_and_compare("R8");
      check(err_run_empty == 1'b1, "R8", "err flag sticky", int'(err_run_empty), 1);
      do_reset();
      #1;
      check(err_run_empty == 1'b0, "R1", "err cleared by reset", int'(err_run_empty), 0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      t_reset();
      t_raw();
      t_exact();
      t_patch();
      t_run();
      t_backpressure();
      t_throughput();
      t_orphan_run();
      report();
   end
endmodule